// File: doc/BRIEF.md
# Translation Table Update Command Engine

This block carries out maintenance commands against a table of 64-bit translation entries, one entry per page of a bus address window. It runs four commands: store one entry, fetch one entry, stamp one value into a run of consecutive pages, and load a run of pages from a list of 64-bit words held in memory. Every command names a table ID, a bus address, a 64-bit argument (the entry value or the list address) and a page count. It ends with a status code. A successful fetch also returns the stored entry.

The table is shared with a translation lookup unit, which reads it combinationally through its own index port. The engine takes one command at a time. A command is accepted when `cmd_valid_i` is high while the engine is idle. `busy_o` stays high until the command finishes. `done_o` pulses for one cycle with the final status. Multi-page commands handle one page per cycle. The list command pulls its words over a simple read port that holds each request until it is acknowledged. A multi-page command stops at the first page that falls outside the table, and the pages already written stay written.

Top module: `xlat_cmd_engine`

## Requirements
- R1: Opcode 0 stores `cmd_arg_i` at index ((address with its low PAGE_SHIFT bits cleared) − BUS_OFFSET) >> PAGE_SHIFT when that index is below N_ENTRIES, and returns status 0. The low page bits of the address have no effect.
- R2: For opcodes 0 and 1, an index not below N_ENTRIES returns status 1 (parameter error) and changes no entry. This includes addresses below BUS_OFFSET, because the subtraction wraps.
- R3: Opcode 1 with an in-range index returns status 0 and places the stored entry on `rdata_o`, where it stays until the next successful read.
- R4: A command whose `cmd_id_i` differs from TABLE_ID returns status 1 and changes no entry.
- R5: Opcode 2 (fill) with a page count above N_ENTRIES returns status 1 and writes nothing. Otherwise it writes `cmd_arg_i` into the consecutive pages that start at the aligned address.
- R6: Opcode 3 (list) with a page count above 512, or with any of the low 12 bits of the list address set, returns status 1, writes nothing and issues no memory request.
- R7: Opcode 3 reads entry i from memory address list address + 8·i and writes it to the page at aligned address + i·page size. Each request is held with a stable address until `mem_ack_i`.
- R8: Opcodes 2 and 3 stop at the first page whose index is out of range and return status 1. Pages written before that page keep their new values.
- R9: Opcodes 2 and 3 with a page count of zero return status 1 without writing or requesting memory.
- R10: `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` is a single-cycle pulse. A `cmd_valid_i` seen while busy is ignored.
- R11: Reset clears every entry to zero and sets `busy_o`, `done_o` and `status_o` to zero. `lk_entry_o` always shows the entry selected by `lk_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_op_i | input | 2 | 0 store, 1 fetch, 2 fill, 3 list |
| cmd_id_i | input | 32 | Target table ID |
| cmd_addr_i | input | AW | Bus address of the first page |
| cmd_arg_i | input | DW | Entry value, or list address for opcode 3 |
| cmd_count_i | input | CW | Page count for opcodes 2 and 3 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 success, 1 parameter error |
| rdata_o | output | DW | Entry returned by the last successful fetch |
| mem_req_o | output | 1 | List word read request |
| mem_addr_o | output | DW | List word byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid with it |
| mem_rdata_i | input | DW | List word read data |
| lk_idx_i | input | IDX_W | Lookup unit entry index |
| lk_entry_o | output | DW | Lookup unit entry value |

## Verification
The assertions assume that memory answers only while `mem_req_o` is high and returns one word per acknowledge. They also assume that nothing except the engine writes the table. The bench drives `mem_ack_i` only in cycles where it observes a request, and it changes command inputs only at the falling edge. Random addresses cover the window, pages just past its end and addresses below the offset. Random counts run from zero to past the table size, with occasional lists longer than 512 words or misaligned.

// File: rtl/xlat_cmd_pkg.sv
`timescale 1ns/1ps
package xlat_cmd_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FILL  = 2'd2,
    OP_LIST  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_FILL,
    S_FETCH
  } state_e;

  localparam logic [1:0] STAT_OK  = 2'd0;
  localparam logic [1:0] STAT_ERR = 2'd1;

  localparam int unsigned LIST_MAX        = 512;
  localparam int unsigned LIST_ALIGN_BITS = 12;
  localparam int unsigned LIST_WORD_BYTES = 8;
endpackage

// File: rtl/xlat_index_calc.sv
`timescale 1ns/1ps
module xlat_index_calc #(
  parameter int unsigned          AW         = 32,
  parameter int unsigned          N_ENTRIES  = 64,
  parameter int unsigned          PAGE_SHIFT = 12,
  parameter int unsigned          IDX_W      = 6,
  parameter logic [AW-1:0]        BUS_OFFSET = '0
) (
  input  logic [AW-1:0]    addr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             in_range_o
);
  logic [AW-1:0] rel;
  logic [AW-1:0] page_no;

  // wrap below the offset yields a huge page number, caught by the range test
  assign rel        = addr_i - BUS_OFFSET;
  assign page_no    = rel >> PAGE_SHIFT;
  assign in_range_o = page_no < AW'(N_ENTRIES);
  assign idx_o      = page_no[IDX_W-1:0];
endmodule

// File: rtl/xlat_entry_table.sv
`timescale 1ns/1ps
module xlat_entry_table #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned DW        = 64,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [DW-1:0]    lk_data_o
);
  logic [DW-1:0] ent_q [N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENTRIES; e++) ent_q[e] <= '0;
    end else if (we_i) begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (wr_idx_i == IDX_W'(e)) ent_q[e] <= wr_data_i;
      end
    end
  end

  generate
    if ((1 << IDX_W) == N_ENTRIES) begin : g_pow2
      assign rd_data_o = ent_q[rd_idx_i];
      assign lk_data_o = ent_q[lk_idx_i];
    end else begin : g_guard
      assign rd_data_o = (int'(rd_idx_i) < N_ENTRIES) ? ent_q[rd_idx_i] : '0;
      assign lk_data_o = (int'(lk_idx_i) < N_ENTRIES) ? ent_q[lk_idx_i] : '0;
    end
  endgenerate
endmodule

// File: rtl/xlat_cmd_ctrl.sv
`timescale 1ns/1ps
module xlat_cmd_ctrl
  import xlat_cmd_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   DW         = 64,
  parameter int unsigned   CW         = 16,
  parameter int unsigned   IDX_W      = 6,
  parameter int unsigned   N_ENTRIES  = 64,
  parameter int unsigned   PAGE_SHIFT = 12,
  parameter logic [31:0]   TABLE_ID   = 32'h42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [31:0]      cmd_id_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [DW-1:0]    cmd_arg_i,
  input  logic [CW-1:0]    cmd_count_i,
  output logic [AW-1:0]    cur_addr_o,
  input  logic             idx_ok_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             tbl_we_o,
  output logic [IDX_W-1:0] tbl_idx_o,
  output logic [DW-1:0]    tbl_data_o,
  output logic             mem_req_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [DW-1:0]    rdata_o
);
  localparam logic [AW-1:0] PAGE_BYTES = AW'(1) << PAGE_SHIFT;
  localparam logic [AW-1:0] PAGE_MASK  = ~(PAGE_BYTES - AW'(1));
  localparam logic [CW-1:0] FILL_LIM   = CW'(N_ENTRIES);
  localparam logic [CW-1:0] LIST_LIM   = CW'(LIST_MAX);

  state_e        state_q, state_d;
  op_e           op_q;
  logic          id_ok_q;
  logic [AW-1:0] cur_q, cur_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          done_q;
  logic [1:0]    status_q;
  logic [DW-1:0] rdata_q;
  logic          fin_ok, fin_err, rd_load, accept;

  assign accept = (state_q == S_IDLE) && cmd_valid_i;

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    ptr_d      = ptr_q;
    rem_d      = rem_q;
    fin_ok     = 1'b0;
    fin_err    = 1'b0;
    rd_load    = 1'b0;
    tbl_we_o   = 1'b0;
    tbl_data_o = ptr_q;
    mem_req_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid_i) begin
          state_d = S_CHECK;
          cur_d   = cmd_addr_i & PAGE_MASK;
          ptr_d   = cmd_arg_i;
          rem_d   = cmd_count_i;
        end
      end
      S_CHECK: begin
        if (!id_ok_q) begin
          fin_err = 1'b1;
        end else begin
          unique case (op_q)
            OP_WRITE: begin
              if (idx_ok_i) begin
                tbl_we_o = 1'b1;
                fin_ok   = 1'b1;
              end else fin_err = 1'b1;
            end
            OP_READ: begin
              if (idx_ok_i) begin
                rd_load = 1'b1;
                fin_ok  = 1'b1;
              end else fin_err = 1'b1;
            end
            OP_FILL: begin
              if (rem_q == '0 || rem_q > FILL_LIM) fin_err = 1'b1;
              else state_d = S_FILL;
            end
            OP_LIST: begin
              if (rem_q == '0 || rem_q > LIST_LIM ||
                  ptr_q[LIST_ALIGN_BITS-1:0] != '0) fin_err = 1'b1;
              else state_d = S_FETCH;
            end
            default: fin_err = 1'b1;
          endcase
        end
      end
      S_FILL: begin
        if (!idx_ok_i) begin
          fin_err = 1'b1;
        end else begin
          tbl_we_o = 1'b1;
          cur_d    = cur_q + PAGE_BYTES;
          rem_d    = rem_q - CW'(1);
          if (rem_q == CW'(1)) fin_ok = 1'b1;
        end
      end
      S_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          if (!idx_ok_i) begin
            fin_err = 1'b1;
          end else begin
            tbl_we_o   = 1'b1;
            tbl_data_o = mem_rdata_i;
            cur_d      = cur_q + PAGE_BYTES;
            ptr_d      = ptr_q + DW'(LIST_WORD_BYTES);
            rem_d      = rem_q - CW'(1);
            if (rem_q == CW'(1)) fin_ok = 1'b1;
          end
        end
      end
      default: fin_err = 1'b1;
    endcase
    if (fin_ok || fin_err) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_WRITE;
      id_ok_q  <= 1'b0;
      cur_q    <= '0;
      ptr_q    <= '0;
      rem_q    <= '0;
      done_q   <= 1'b0;
      status_q <= STAT_OK;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      done_q  <= fin_ok | fin_err;
      if (accept) begin
        op_q    <= op_e'(cmd_op_i);
        id_ok_q <= (cmd_id_i == TABLE_ID);
      end
      if (fin_ok || fin_err) status_q <= fin_err ? STAT_ERR : STAT_OK;
      if (rd_load) rdata_q <= rd_data_i;
    end
  end

  assign cur_addr_o = cur_q;
  assign tbl_idx_o  = idx_i;
  assign mem_addr_o = ptr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign rdata_o    = rdata_q;

  AST_WE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> idx_ok_i) else $error("write outside table"); // R8
  AST_NO_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tbl_we_o) else $error("write while idle"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done held"); // R10
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o) else $error("busy dropped without done"); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)))
    else $error("request dropped"); // R7
  AST_REQ_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0)) else $error("unaligned word"); // R7
endmodule

// File: rtl/xlat_cmd_engine.sv
`timescale 1ns/1ps
module xlat_cmd_engine
  import xlat_cmd_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 64,
  parameter int unsigned CW         = 16,
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter logic [AW-1:0] BUS_OFFSET = 32'h0010_0000,
  parameter logic [31:0] TABLE_ID   = 32'h0000_0042,
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [31:0]      cmd_id_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [DW-1:0]    cmd_arg_i,
  input  logic [CW-1:0]    cmd_count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [DW-1:0]    rdata_o,
  output logic             mem_req_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [DW-1:0]    lk_entry_o
);
  logic [AW-1:0]    cur_addr;
  logic [IDX_W-1:0] idx, tbl_idx;
  logic             idx_ok, tbl_we;
  logic [DW-1:0]    tbl_data, rd_data;

  xlat_index_calc #(
    .AW(AW), .N_ENTRIES(N_ENTRIES), .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W(IDX_W), .BUS_OFFSET(BUS_OFFSET)
  ) u_idx (
    .addr_i(cur_addr), .idx_o(idx), .in_range_o(idx_ok)
  );

  xlat_entry_table #(
    .N_ENTRIES(N_ENTRIES), .DW(DW), .IDX_W(IDX_W)
  ) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(tbl_we), .wr_idx_i(tbl_idx), .wr_data_i(tbl_data),
    .rd_idx_i(idx), .rd_data_o(rd_data),
    .lk_idx_i(lk_idx_i), .lk_data_o(lk_entry_o)
  );

  xlat_cmd_ctrl #(
    .AW(AW), .DW(DW), .CW(CW), .IDX_W(IDX_W), .N_ENTRIES(N_ENTRIES),
    .PAGE_SHIFT(PAGE_SHIFT), .TABLE_ID(TABLE_ID)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_id_i(cmd_id_i),
    .cmd_addr_i(cmd_addr_i), .cmd_arg_i(cmd_arg_i), .cmd_count_i(cmd_count_i),
    .cur_addr_o(cur_addr), .idx_ok_i(idx_ok), .idx_i(idx), .rd_data_i(rd_data),
    .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx), .tbl_data_o(tbl_data),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .rdata_o(rdata_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o) else $error("start overlaps done"); // R10
  AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_ack_i) |-> mem_req_o) else $error("stray ack"); // R7
endmodule

// File: tb/xlat_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module xlat_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 64;
  localparam int IDX_W      = 6;
  localparam int PAGE       = 4096;
  localparam logic [31:0] OFFS = 32'h0010_0000;
  localparam logic [31:0] TID  = 32'h0000_0042;
  localparam logic [63:0] LBASE = 64'h0000_0008_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_id = '0, cmd_addr = '0;
  logic [63:0] cmd_arg = '0;
  logic [15:0] cmd_cnt = '0;
  logic busy, done, mem_req;
  logic [1:0] status;
  logic [63:0] rdata, mem_addr, lk_entry;
  logic mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [IDX_W-1:0] lk_idx = '0;

  int total = 0, bad = 0;
  logic [63:0] model [N];
  logic [1:0]  exp_status;
  logic [63:0] exp_rdata;
  int          exp_reqs;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cmd_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_id_i(cmd_id), .cmd_addr_i(cmd_addr), .cmd_arg_i(cmd_arg),
    .cmd_count_i(cmd_cnt), .busy_o(busy), .done_o(done), .status_o(status),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .lk_idx_i(lk_idx),
    .lk_entry_o(lk_entry)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5C3_0000, ~a[31:0]};
  endfunction

  function automatic bit idx_of(input logic [31:0] a, output int idx);
    logic [31:0] rel;
    rel = (a & ~32'(PAGE - 1)) - OFFS;
    idx = int'(rel[31:12]);
    return (rel >> 12) < 32'(N);
  endfunction

  task automatic model_cmd(input logic [1:0] op, input logic [31:0] id,
                           input logic [31:0] addr, input logic [63:0] arg,
                           input int cnt);
    int ix;
    logic [31:0] a;
    exp_reqs = 0;
    exp_status = 2'd1;
    if (id != TID) return;
    a = addr & ~32'(PAGE - 1);
    case (op)
      2'd0: if (idx_of(a, ix)) begin model[ix] = arg; exp_status = 2'd0; end
      2'd1: if (idx_of(a, ix)) begin exp_rdata = model[ix]; exp_status = 2'd0; end
      2'd2: begin
        if (cnt == 0 || cnt > N) return;
        for (int i = 0; i < cnt; i++) begin
          if (!idx_of(a + 32'(i * PAGE), ix)) return;
          model[ix] = arg;
        end
        exp_status = 2'd0;
      end
      default: begin
        if (cnt == 0 || cnt > 512 || arg[11:0] != 12'd0) return;
        for (int i = 0; i < cnt; i++) begin
          exp_reqs++;
          if (!idx_of(a + 32'(i * PAGE), ix)) return;
          model[ix] = mem_fn(arg + 64'(8 * i));
        end
        exp_status = 2'd0;
      end
    endcase
  endtask

  task automatic cmp_table(input string req);
    int mism = 0;
    logic [63:0] first_act = '0, first_exp = '0;
    for (int i = 0; i < N; i++) begin
      lk_idx = IDX_W'(i);
      #1;
      if (lk_entry !== model[i]) begin
        if (mism == 0) begin first_act = lk_entry; first_exp = model[i]; end
        mism++;
      end
      @(negedge clk);
    end
    chk(mism == 0, req, first_act, first_exp);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] id,
                         input logic [31:0] addr, input logic [63:0] arg,
                         input int cnt, input string req, input bit poke);
    int reqs = 0, waited = 0;
    model_cmd(op, id, addr, arg, cnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_addr = addr;
    cmd_arg = arg; cmd_cnt = 16'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
    while (!done && waited < 3000) begin
      if (poke && waited == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = TID;
        cmd_addr = OFFS; cmd_arg = 64'hBAD0_BAD0_BAD0_BAD0;
      end else cmd_valid = 1'b0;
      if (mem_req) begin
        mem_ack = 1'b1; mem_rdata = mem_fn(mem_addr); reqs++;
      end else mem_ack = 1'b0;
      @(negedge clk);
      waited++;
    end
    cmd_valid = 1'b0; mem_ack = 1'b0;
    chk(done === 1'b1, {req, " completion"}, 64'(done), 64'd1);
    chk(status === exp_status, {req, " status"}, 64'(status), 64'(exp_status));
    if (op == 2'd1 && exp_status == 2'd0)
      chk(rdata === exp_rdata, "R3 read data", rdata, exp_rdata);
    if (op == 2'd3)
      chk(reqs == exp_reqs, {req, " memory fetches"}, 64'(reqs), 64'(exp_reqs));
    @(negedge clk);
    chk(done === 1'b0, "R10 done pulse width", 64'(done), 64'd0);
    cmp_table({req, " table"});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0]  op;
    logic [31:0] id, addr;
    logic [63:0] arg;
    int          cnt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) model[i] = '0;
    exp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R11 reset idle", {62'd0, busy, done}, 64'd0);
    chk(status === 2'd0, "R11 reset status", 64'(status), 64'd0);
    cmp_table("R11 reset table");

    run_cmd(2'd0, TID, OFFS + 32'h0000_0ABC, 64'h1111_2222_3333_4444, 0, "R1 write low bits", 0);
    run_cmd(2'd1, TID, OFFS + 32'h0000_0FF8, 64'd0, 0, "R3 read", 0);
    run_cmd(2'd0, TID, OFFS + 32'((N - 1) * PAGE), 64'h5555_AAAA_0000_FFFF, 0, "R1 last", 0);
    run_cmd(2'd0, TID, OFFS + 32'(N * PAGE), 64'h77, 0, "R2 past end", 0);
    run_cmd(2'd1, TID, OFFS - 32'd8, 64'd0, 0, "R2 below offset", 0);
    run_cmd(2'd0, TID + 32'd1, OFFS, 64'h99, 0, "R4 wrong id", 0);
    run_cmd(2'd2, TID, OFFS, 64'hFEED, N + 1, "R5 fill too long", 0);
    run_cmd(2'd2, TID, OFFS, 64'hC0DE_0001, N, "R5 fill all", 0);
    run_cmd(2'd2, TID, OFFS + 32'((N - 1) * PAGE), 64'hAB, 3, "R8 fill overrun", 0);
    run_cmd(2'd2, TID, OFFS, 64'hEE, 0, "R9 fill zero", 0);
    run_cmd(2'd3, TID, OFFS, LBASE, 513, "R6 list too long", 0);
    run_cmd(2'd3, TID, OFFS, LBASE + 64'h8, 2, "R6 list misaligned", 0);
    run_cmd(2'd3, TID, OFFS + 32'(4 * PAGE), LBASE + 64'h3000, 4, "R7 list", 0);
    run_cmd(2'd3, TID, OFFS + 32'((N - 2) * PAGE), LBASE, 4, "R8 list overrun", 0);
    run_cmd(2'd3, TID, OFFS, LBASE, 0, "R9 list zero", 0);
    run_cmd(2'd2, TID, OFFS + 32'(8 * PAGE), 64'h1234, 6, "R10 ignore while busy", 1);

    for (int k = 0; k < 150; k++) begin
      op   = 2'($urandom % 4);
      id   = ($urandom % 10 == 0) ? TID ^ 32'h1 : TID;
      addr = OFFS + 32'(($urandom % (N + 6)) * PAGE) + 32'($urandom % PAGE);
      if ($urandom % 12 == 0) addr = OFFS - 32'h1000;
      arg  = {$urandom, $urandom};
      cnt  = 0;
      if (op == 2'd2) cnt = int'($urandom % (N + 3));
      if (op == 2'd3) begin
        cnt = int'($urandom % 14);
        if ($urandom % 15 == 0) cnt = 513;
        arg = LBASE + 64'(($urandom % 16) * PAGE);
        if ($urandom % 10 == 0) arg = arg + 64'h10;
      end
      run_cmd(op, id, addr, arg, cnt,
              op == 2'd2 ? "R5 random fill" : op == 2'd3 ? "R7 random list" :
              op == 2'd1 ? "R3 random read" : "R1 random write", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule